// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two N-bit two's-complement numbers and returns their full 2N-bit signed product. It uses radix-2 Booth recoding and retires one recoded multiplier bit per clock. A product therefore takes N clocks after the operands are accepted. It suits datapaths that need an occasional signed multiply and have little area to spend on one.

The caller raises `start` for one cycle while `busy` is low, with both operands on the inputs. The block captures them at that clock edge and holds `busy` high while it iterates. When the result is ready, `done` is high for exactly one cycle. `product` keeps the result until the next start is accepted.

The working register and both addend registers are one bit wider than the plain algorithm requires. Because of this extra bit, the negated multiplicand stays representable when the multiplicand is the most negative value.

Top module: `booth_mult`

## Requirements
- R1: A synchronous active-low reset drives `busy` and `done` low on the next clock edge, even in the middle of a multiplication.
- R2: A `start` that is high at a clock edge while `busy` is low captures `mcand` and `mplier` at that edge, and `busy` is high from that edge on.
- R3: `done` goes high exactly N clock edges after the edge that accepted `start`, stays high for one cycle only, and `busy` falls at that same edge. `busy` and `done` are never high together.
- R4: When `done` is high, `product` equals the signed product mcand × mplier for every operand pair. With N=4, 3 × -4 gives 8'b11110100.
- R5: A multiplicand equal to the most negative value -2^(N-1) gives the correct product. With N=4, -8 × 2 gives 8'b11110000 (-16).
- R6: -2^(N-1) × -2^(N-1) gives +2^(2N-2), which fits the 2N-bit output. With N=4 the result is 8'b01000000.
- R7: A `start` that arrives while `busy` is high is ignored. The operands in flight, the result and the latency are all unchanged.
- R8: After `done`, `product` keeps its value until the next accepted `start`, whatever the operand inputs do in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiply; accepted only while idle |
| mcand | input | N | Signed multiplicand |
| mplier | input | N | Signed multiplier |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse when `product` is valid |
| product | output | 2N | Signed product; held after `done` |

## Verification
The assertions assume that `start` is a clean synchronous level and that no outside logic disturbs the operands once they are captured. They do not assume that `start` is withheld while the block is busy. The stimulus changes every input on the falling clock edge. It deliberately raises `start` in the middle of a run and changes the operand inputs after completion, so that both the rule that ignores such a `start` and the rule that holds the product are exercised. The N=4 sweep covers all 256 operand pairs, the most negative multiplicand among them, and the N=8 instance receives random pairs together with its own extreme corners.

// File: rtl/booth_pkg.sv
// Package booth_pkg
// Shared types for the sequential Booth multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package booth_pkg;

    // Controller phases: waiting for work, or iterating.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } booth_phase_t;

endpackage

// File: rtl/booth_step.sv
// Module booth_step
// One radix-2 Booth iteration in combinational logic. It examines the two
// lowest bits of the working word and adds the positive addend (pair 01),
// adds the negative addend (pair 10) or adds nothing (00, 11). It then
// shifts the sum right by one place, keeping the sign.
// Assumes: both addends already sit in the upper, guard-extended field.
module booth_step #(
    parameter int W = 10
) (
    input  logic [W-1:0] work_in,
    input  logic [W-1:0] add_pos,
    input  logic [W-1:0] add_neg,
    output logic [W-1:0] work_out
);

    logic [W-1:0] sum;

    // Choose the addend from the recoded bit pair and shift the sum.
    always_comb begin
        unique case (work_in[1:0])
            2'b01:   sum = work_in + add_pos;
            2'b10:   sum = work_in + add_neg;
            default: sum = work_in;
        endcase
        work_out = {sum[W-1], sum[W-1:1]};
    end

endmodule

// File: rtl/booth_ctrl.sv
// Module booth_ctrl
// Sequencer: it accepts start only while idle, counts N iterations and
// then pulses done for one cycle.
// Assumes: start is synchronous to clk. Reset is synchronous and active low.
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step_en,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    booth_phase_t    phase;
    logic [CW-1:0]   iter;

    assign load    = start && (phase == PH_IDLE);
    assign step_en = (phase == PH_RUN);
    assign busy    = (phase == PH_RUN);

    // Phase, iteration count and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            iter  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                phase <= PH_RUN;
                iter  <= '0;
            end else if (phase == PH_RUN) begin
                if (iter == LAST) begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end
                iter <= iter + 1'b1;
            end
        end
    end

    // R1: reset clears the handshake outputs on the next edge.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done));

    // R3: done lasts one cycle only.
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: busy and done never overlap.
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R3: the iteration count stays within N while running.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (iter < CW'(N)));

    // R7: start while busy does not restart; the run continues or completes.
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && iter != LAST) |=> (busy && iter == $past(iter) + 1'b1));

endmodule

// File: rtl/booth_datapath.sv
// Module booth_datapath
// Holds the working word {guard, upper N, lower N, trailing bit} and the two
// precomputed addends (+multiplicand and -multiplicand in the upper field).
// Assumes: load and step_en are never high together.
module booth_datapath #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step_en,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic [2*N-1:0] result
);

    localparam int W  = 2 * N + 2;
    localparam int HW = N + 1;

    logic [W-1:0]  work_q, work_nx;
    logic [W-1:0]  add_pos_q, add_neg_q;
    logic [HW-1:0] mc_ext, mc_neg;

    // Guard-extended multiplicand and its negation.
    always_comb begin
        mc_ext = {mcand[N-1], mcand};
        mc_neg = (~mc_ext) + 1'b1;
    end

    booth_step #(.W(W)) u_step (
        .work_in  (work_q),
        .add_pos  (add_pos_q),
        .add_neg  (add_neg_q),
        .work_out (work_nx)
    );

    // Load operands on accept, then iterate one step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q    <= '0;
            add_pos_q <= '0;
            add_neg_q <= '0;
        end else if (load) begin
            work_q    <= {{HW{1'b0}}, mplier, 1'b0};
            add_pos_q <= {mc_ext, {HW{1'b0}}};
            add_neg_q <= {mc_neg, {HW{1'b0}}};
        end else if (step_en) begin
            work_q <= work_nx;
        end
    end

    assign result = work_q[W-2:1];

    // R5: the two addends stay exact negations, even for the most negative value.
    a_r5_addend_negation: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> ((add_pos_q[W-1:HW] + add_neg_q[W-1:HW]) == '0));

    // R7: the addends cannot change during a run.
    a_r7_addends_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && $past(step_en)) |-> ($stable(add_pos_q) && $stable(add_neg_q)));

    // R8: the working word holds while neither loading nor stepping.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load) && !$past(step_en)) |-> $stable(work_q));

    // R6: the guard bit agrees with the product sign when idle, so 2N bits suffice.
    a_r6_guard_fit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(step_en) && !step_en) |-> (work_q[W-1] == work_q[W-2]));

endmodule

// File: rtl/booth_mult.sv
// Module booth_mult
// Top of the sequential radix-2 Booth signed multiplier: it ties the
// sequencer to the datapath.
// Assumes: operands are two's complement; N >= 2.
module booth_mult #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);

    logic load, step_en;

    booth_ctrl #(.N(N)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load    (load),
        .step_en (step_en),
        .busy    (busy),
        .done    (done)
    );

    booth_datapath #(.N(N)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step_en (step_en),
        .mcand   (mcand),
        .mplier  (mplier),
        .result  (product)
    );

    // R2: an accepted start makes busy high on the next edge.
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8: the product is stable between done and the next accepted start.
    a_r8_product_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done) && !busy) |-> $stable(product));

endmodule

// File: tb/sim_booth_mult.sv
// Bench sim_booth_mult: it sweeps every operand pair of an N=4 instance and
// random and corner pairs of an N=8 instance, comparing against a signed multiply.
module sim_booth_mult;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic       s4 = 1'b0;
    logic [3:0] a4 = '0, b4 = '0;
    logic       busy4, done4;
    logic [7:0] p4;

    logic        s8 = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic        busy8, done8;
    logic [15:0] p8;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    booth_mult #(.N(4)) u0 (
        .clk(clk), .rst_n(rst_n), .start(s4), .mcand(a4), .mplier(b4),
        .busy(busy4), .done(done4), .product(p4)
    );

    booth_mult #(.N(8)) u1 (
        .clk(clk), .rst_n(rst_n), .start(s8), .mcand(a8), .mplier(b8),
        .busy(busy8), .done(done8), .product(p8)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // One N=4 multiply. It checks latency, result, the done pulse and the held product.
    task automatic mul4(input logic signed [3:0] x, input logic signed [3:0] y,
                        input bit interrupt, input string req);
        int n;
        logic signed [7:0] exp;
        exp = 8'(x * y);
        @(negedge clk); s4 = 1'b1; a4 = x; b4 = y;
        @(negedge clk); s4 = 1'b0; n = 1;
        if (interrupt) begin
            s4 = 1'b1; a4 = 4'sd7; b4 = 4'sd7;   // R7: start while busy
            @(negedge clk); s4 = 1'b0; n++;
        end
        while (!done4 && n < 40) begin @(negedge clk); n++; end
        chk(n == 5, "R3 latency", n, 5);
        chk(p4 == exp, req, $signed(p4), exp);
        a4 = ~x; b4 = ~y;
        @(negedge clk);
        chk(!done4, "R3 one-cycle done", done4, 0);
        chk(p4 == exp, "R8 held product", $signed(p4), exp);
    endtask

    task automatic mul8(input logic signed [7:0] x, input logic signed [7:0] y, input string req);
        int n;
        logic signed [15:0] exp;
        exp = 16'(x * y);
        @(negedge clk); s8 = 1'b1; a8 = x; b8 = y;
        @(negedge clk); s8 = 1'b0; n = 1;
        while (!done8 && n < 60) begin @(negedge clk); n++; end
        chk(n == 9, "R3 latency N=8", n, 9);
        chk(p8 == exp, req, $signed(p8), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy4 && !done4, "R1 reset state", {busy4, done4}, 0);
        chk(!busy8 && !done8, "R1 reset state N=8", {busy8, done8}, 0);
        rst_n = 1'b1;

        // R2: busy rises at the accepting edge.
        @(negedge clk); s4 = 1'b1; a4 = 4'sd1; b4 = 4'sd1;
        @(negedge clk); s4 = 1'b0;
        chk(busy4, "R2 busy after accept", busy4, 1);
        // R1: reset in the middle of a run.
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy4 && !done4, "R1 mid-run reset", {busy4, done4}, 0);
        rst_n = 1'b1;

        mul4(4'sd3, -4'sd4, 1'b0, "R4 3*-4");
        mul4(-4'sd8, 4'sd2, 1'b0, "R5 -8*2");
        mul4(-4'sd8, -4'sd8, 1'b0, "R6 -8*-8");
        mul4(4'sd3, 4'sd5, 1'b1, "R7 start ignored while busy");

        // R4 and R5: exhaustive sweep of N=4.
        for (int i = -8; i < 8; i++)
            for (int j = -8; j < 8; j++)
                mul4(4'(i), 4'(j), 1'b0, (i == -8) ? "R5 sweep" : "R4 sweep");

        mul8(-8'sd128, -8'sd128, "R6 N=8 extreme");
        mul8(-8'sd128, 8'sd127, "R5 N=8 most negative");
        mul8(8'sd127, 8'sd127, "R4 N=8 max");
        for (int k = 0; k < 300; k++)
            mul8(8'($urandom), 8'($urandom), "R4 N=8 random");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule